// File: doc/BRIEF.md
# Pipelined Restoring Integer Divider

This block computes the quotient and remainder of two WIDTH-bit integers. It is built as a chain of registered shift-subtract stages. A new operand pair can be accepted on every clock, and every result comes out a fixed number of cycles later, in the order the pairs went in. Each stage carries a valid bit and the sign flags next to the data, so gaps in the input stream show up as gaps at the output.

When signed operation is selected, an input stage records the operand signs and strips them off. The stage chain divides the magnitudes, and an output stage puts the signs back. The parameter STEPS_PER_STAGE sets how many trial subtractions share one register stage (1 or 2). A value of 2 halves the number of stages but lengthens the logic path in each one. A zero divisor gives a fixed, flagged result.

Top module: `div_pipe`

## Requirements
- R1: While reset is asserted, and afterwards until the first result appears, out_valid is low.
- R2: For a non-zero divisor, dividend = quotient * divisor + remainder, and |remainder| < |divisor|.
- R3: One operand pair is accepted on every clock in which in_valid is high. Results come out in input order, one per clock for back-to-back inputs. out_valid is low in the cycles that correspond to idle input cycles.
- R4: A result is presented exactly LAT = WIDTH/STEPS_PER_STAGE + 2 clock edges after its operands are sampled.
- R5: With SIGNED_OPS=1, operands are two's complement and the quotient truncates toward zero. The quotient is negative when exactly one operand is negative.
- R6: With SIGNED_OPS=1, a non-zero remainder has the same sign as the dividend.
- R7: A zero divisor gives an all-ones quotient, a remainder equal to the dividend as given, and out_div_zero high. out_div_zero is low for every non-zero divisor.
- R8: With SIGNED_OPS=1, the most negative dividend divided by -1 wraps to a quotient equal to the most negative value, with remainder 0.
- R9: With STEPS_PER_STAGE=2, results are identical to those of the one-step build, and the latency is WIDTH/2 + 2.
- R10: With SIGNED_OPS=0, both operands are treated as unsigned values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand pair present this cycle |
| in_dividend | input | WIDTH | Dividend |
| in_divisor | input | WIDTH | Divisor |
| out_valid | output | 1 | Result present this cycle |
| out_quotient | output | WIDTH | Quotient |
| out_remainder | output | WIDTH | Remainder |
| out_div_zero | output | 1 | Result came from a zero divisor |

## Verification
The bench targets the sign combinations and the operands that break naive designs:
- A design that fixed signs wrongly would return a positive quotient for mixed signs, or a remainder signed like the divisor.
- A design that mishandles the most negative dividend divided by -1 would saturate or corrupt that result instead of wrapping.
- A design that got the zero-divisor case wrong would leak a sign-corrected quotient instead of all ones, or drop the flag.

A signed one-step build and an unsigned two-step build run side by side on the same stream. The stream includes back-to-back inputs and gaps, so a lost pipeline stage, a stalled valid bit or a wrong latency shows up as a result that is early, late, missing or out of order.

// File: rtl/div_pkg.sv
package div_pkg;

  // Side information that travels with every operand pair.
  typedef struct packed {
    logic q_neg;   // quotient must be negated at the output
    logic r_neg;   // remainder must be negated at the output
    logic dz;      // divisor was zero
  } div_tag_t;

endpackage

// File: rtl/div_front.sv
module div_front
  import div_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit SIGNED_OPS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_dividend,
  input  logic [WIDTH-1:0] in_divisor,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_dvd_mag,
  output logic [WIDTH-1:0] out_dvs_mag,
  output div_tag_t         out_tag
);

  logic             dvd_neg, dvs_neg;
  logic [WIDTH-1:0] dvd_mag_nx, dvs_mag_nx;
  div_tag_t         tag_nx;

  always_comb begin
    dvd_neg    = SIGNED_OPS & in_dividend[WIDTH-1];
    dvs_neg    = SIGNED_OPS & in_divisor[WIDTH-1];
    dvd_mag_nx = dvd_neg ? (~in_dividend + 1'b1) : in_dividend;
    dvs_mag_nx = dvs_neg ? (~in_divisor + 1'b1) : in_divisor;
    tag_nx.q_neg = dvd_neg ^ dvs_neg;
    tag_nx.r_neg = dvd_neg;
    tag_nx.dz    = (in_divisor == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_dvd_mag <= dvd_mag_nx;
      out_dvs_mag <= dvs_mag_nx;
      out_tag     <= tag_nx;
    end
  end

endmodule

// File: rtl/div_stage.sv
module div_stage
  import div_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int STEPS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_rem,
  input  logic [WIDTH-1:0] in_work,
  input  logic [WIDTH-1:0] in_dvs,
  input  div_tag_t         in_tag,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_rem,
  output logic [WIDTH-1:0] out_work,
  output logic [WIDTH-1:0] out_dvs,
  output div_tag_t         out_tag
);

  // in_work holds the dividend bits not yet consumed in its upper part.
  // Quotient bits fill it from the bottom.
  logic [WIDTH-1:0] rem_nx, work_nx;
  logic [WIDTH:0]   shifted, trial;

  always_comb begin
    rem_nx  = in_rem;
    work_nx = in_work;
    shifted = '0;
    trial   = '0;
    for (int s = 0; s < STEPS; s++) begin
      shifted = {rem_nx, work_nx[WIDTH-1]};
      trial   = shifted - {1'b0, in_dvs};
      if (!trial[WIDTH]) begin
        rem_nx  = trial[WIDTH-1:0];
        work_nx = {work_nx[WIDTH-2:0], 1'b1};
      end else begin
        rem_nx  = shifted[WIDTH-1:0];
        work_nx = {work_nx[WIDTH-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_rem  <= rem_nx;
      out_work <= work_nx;
      out_dvs  <= in_dvs;
      out_tag  <= in_tag;
    end
  end

endmodule

// File: rtl/div_back.sv
module div_back
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_quot_mag,
  input  logic [WIDTH-1:0] in_rem_mag,
  input  div_tag_t         in_tag,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_quotient,
  output logic [WIDTH-1:0] out_remainder,
  output logic             out_div_zero
);

  logic [WIDTH-1:0] quot_nx, rem_nx;

  always_comb begin
    if (in_tag.dz)         quot_nx = '1;
    else if (in_tag.q_neg) quot_nx = ~in_quot_mag + 1'b1;
    else                   quot_nx = in_quot_mag;
    rem_nx = in_tag.r_neg ? (~in_rem_mag + 1'b1) : in_rem_mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_vld;
  end

  always_ff @(posedge clk) begin
    if (in_vld) begin
      out_quotient  <= quot_nx;
      out_remainder <= rem_nx;
      out_div_zero  <= in_tag.dz;
    end
  end

endmodule

// File: rtl/div_pipe.sv
module div_pipe
  import div_pkg::*;
#(
  parameter int WIDTH           = 8,
  parameter int STEPS_PER_STAGE = 1,   // 1 or 2; must divide WIDTH
  parameter bit SIGNED_OPS      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_dividend,
  input  logic [WIDTH-1:0] in_divisor,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_quotient,
  output logic [WIDTH-1:0] out_remainder,
  output logic             out_div_zero
);

  localparam int NSTAGE = WIDTH / STEPS_PER_STAGE;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [NSTAGE:0]  vld_p;
  logic [WIDTH-1:0] rem_p  [0:NSTAGE];
  logic [WIDTH-1:0] work_p [0:NSTAGE];
  logic [WIDTH-1:0] dvs_p  [0:NSTAGE];
  div_tag_t         tag_p  [0:NSTAGE];

  assign rem_p[0] = '0;

  div_front #(.WIDTH(WIDTH), .SIGNED_OPS(SIGNED_OPS)) i_front (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .in_valid    (in_valid),
    .in_dividend (in_dividend),
    .in_divisor  (in_divisor),
    .out_vld     (vld_p[0]),
    .out_dvd_mag (work_p[0]),
    .out_dvs_mag (dvs_p[0]),
    .out_tag     (tag_p[0])
  );

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    div_stage #(.WIDTH(WIDTH), .STEPS(STEPS_PER_STAGE)) i_stage (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .in_vld   (vld_p[k]),
      .in_rem   (rem_p[k]),
      .in_work  (work_p[k]),
      .in_dvs   (dvs_p[k]),
      .in_tag   (tag_p[k]),
      .out_vld  (vld_p[k+1]),
      .out_rem  (rem_p[k+1]),
      .out_work (work_p[k+1]),
      .out_dvs  (dvs_p[k+1]),
      .out_tag  (tag_p[k+1])
    );
  end

  div_back #(.WIDTH(WIDTH)) i_back (
    .clk           (clk),
    .rst_n         (rst_q_n),
    .in_vld        (vld_p[NSTAGE]),
    .in_quot_mag   (work_p[NSTAGE]),
    .in_rem_mag    (rem_p[NSTAGE]),
    .in_tag        (tag_p[NSTAGE]),
    .out_valid     (out_valid),
    .out_quotient  (out_quotient),
    .out_remainder (out_remainder),
    .out_div_zero  (out_div_zero)
  );

endmodule

// File: rtl/div_pipe_chk.sv
module div_pipe_chk #(
  parameter int WIDTH           = 8,
  parameter int STEPS_PER_STAGE = 1,
  parameter bit SIGNED_OPS      = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [WIDTH-1:0] in_dividend,
  input logic [WIDTH-1:0] in_divisor,
  input logic             out_valid,
  input logic [WIDTH-1:0] out_quotient,
  input logic [WIDTH-1:0] out_remainder,
  input logic             out_div_zero
);

  localparam int LAT = WIDTH / STEPS_PER_STAGE + 2;

  // Operand history, indexed by the number of edges since sampling.
  logic [LAT-1:0]   h_v;
  logic [WIDTH-1:0] h_dvd [0:LAT-1];
  logic [WIDTH-1:0] h_dvs [0:LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_v <= '0;
    else        h_v <= {h_v[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    h_dvd[0] <= in_dividend;
    h_dvs[0] <= in_divisor;
    for (int j = 1; j < LAT; j++) begin
      h_dvd[j] <= h_dvd[j-1];
      h_dvs[j] <= h_dvs[j-1];
    end
  end

  function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] x);
    return (SIGNED_OPS && x[WIDTH-1]) ? (~x + 1'b1) : x;
  endfunction

  // R1: no result while reset is applied
  always_ff @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!out_valid);
  end

  a_r4_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == h_v[LAT-1]);

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_div_zero == (h_dvs[LAT-1] == '0)));

  a_r7_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_div_zero) |->
      (out_quotient == '1 && out_remainder == h_dvd[LAT-1]));

  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_div_zero) |-> (mag(out_remainder) < mag(h_dvs[LAT-1])));

  a_r6_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (SIGNED_OPS && out_valid && !out_div_zero && out_remainder != '0) |->
      (out_remainder[WIDTH-1] == h_dvd[LAT-1][WIDTH-1]));

endmodule

bind div_pipe div_pipe_chk #(
  .WIDTH(WIDTH), .STEPS_PER_STAGE(STEPS_PER_STAGE), .SIGNED_OPS(SIGNED_OPS)
) i_div_pipe_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_dividend   (in_dividend),
  .in_divisor    (in_divisor),
  .out_valid     (out_valid),
  .out_quotient  (out_quotient),
  .out_remainder (out_remainder),
  .out_div_zero  (out_div_zero)
);

// File: tb/test_div_pipe.sv
`timescale 1ns/1ps
module test_div_pipe;

  localparam int W     = 8;
  localparam int LAT_A = W + 2;       // signed, one step per stage
  localparam int LAT_B = W / 2 + 2;   // unsigned, two steps per stage

  logic clk = 1'b0;
  always #4 clk = ~clk;               // 125 MHz

  logic         rst_n, in_valid;
  logic [W-1:0] in_dividend, in_divisor;
  logic         va, vb, za, zb;
  logic [W-1:0] qa, ra, qb, rb;

  div_pipe #(.WIDTH(W), .STEPS_PER_STAGE(1), .SIGNED_OPS(1'b1)) i_div_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(va), .out_quotient(qa), .out_remainder(ra), .out_div_zero(za));

  div_pipe #(.WIDTH(W), .STEPS_PER_STAGE(2), .SIGNED_OPS(1'b0)) i_div_pipe_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(vb), .out_quotient(qb), .out_remainder(rb), .out_div_zero(zb));

  typedef struct {
    logic [W-1:0] q;
    logic [W-1:0] r;
    logic         dz;
    int           cyc;
    string        req;
  } exp_t;

  exp_t sb_a[$];
  exp_t sb_b[$];
  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input bit sgn, input int lat, input string req);
    exp_t e;
    int sa, sb;
    e.cyc = cyc + lat;
    e.req = req;
    e.dz  = (b == '0);
    if (b == '0) begin
      e.q = '1;
      e.r = a;
    end else if (sgn) begin
      sa  = $signed(a);
      sb  = $signed(b);
      e.q = W'(sa / sb);
      e.r = W'(sa % sb);
    end else begin
      e.q = a / b;
      e.r = a % b;
    end
    return e;
  endfunction

  // Driver: one operand pair in the coming clock edge.
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    sb_a.push_back(model(a, b, 1'b1, LAT_A, req));
    sb_b.push_back(model(a, b, 1'b0, LAT_B, "R9 R10"));
    in_valid    = 1'b1;
    in_dividend = a;
    in_divisor  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitors: compare every result against the head of the queue.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && va === 1'b1) begin
      if (sb_a.size() == 0) check("R3", "A unexpected result", 1'b0, 1, 0);
      else begin
        exp_t e;
        e = sb_a.pop_front();
        check("R4", "A latency cycle", cyc == e.cyc, cyc, e.cyc);
        check(e.req, "A quotient", qa === e.q, qa, e.q);
        check(e.req, "A remainder", ra === e.r, ra, e.r);
        check("R7", "A zero flag", za === e.dz, za, e.dz);
      end
    end
    if (rst_n === 1'b1 && vb === 1'b1) begin
      if (sb_b.size() == 0) check("R3", "B unexpected result", 1'b0, 1, 0);
      else begin
        exp_t e;
        e = sb_b.pop_front();
        check("R9", "B latency cycle", cyc == e.cyc, cyc, e.cyc);
        check(e.req, "B quotient", qb === e.q, qb, e.q);
        check(e.req, "B remainder", rb === e.r, rb, e.r);
        check("R7", "B zero flag", zb === e.dz, zb, e.dz);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_dividend = '0;
    in_divisor  = '0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset A", va === 1'b0, va, 0);
    check("R1", "valid in reset B", vb === 1'b0, vb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "valid after reset A", va === 1'b0, va, 0);
    check("R1", "valid after reset B", vb === 1'b0, vb, 0);

    // Directed cases, back to back.
    send(8'd100, 8'd7,   "R2");
    send(8'd7,   8'd100, "R2");
    send(8'd0,   8'd3,   "R2");
    send(-8'sd100, 8'd7,   "R5 R6");
    send(8'd100,  -8'sd7,  "R5 R6");
    send(-8'sd100, -8'sd7, "R5 R6");
    send(8'h80, 8'hFF, "R8");
    send(8'h80, 8'h01, "R5");
    send(8'h7F, 8'h80, "R5 R6");
    send(8'd5,  8'd0,  "R7");
    send(8'hFB, 8'd0,  "R7");
    send(8'd0,  8'd0,  "R7");
    send(8'hFF, 8'h01, "R10");
    idle(3);
    check("R3", "no result in gap A", va === 1'b0 || sb_a.size() != 0, va, 0);

    // Dense stream, then a stream with gaps.
    lfsr = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      a    = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send(a, (i % 37 == 0) ? 8'd0 : lfsr, "R2 R3");
    end
    for (int i = 0; i < 100; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send(lfsr, {lfsr[3:0], lfsr[7:4]} | 8'h01, "R3");
      idle(i % 3);
    end

    idle(LAT_A + 4);
    check("R3", "all A results seen", sb_a.size() == 0, sb_a.size(), 0);
    check("R3", "all B results seen", sb_b.size() == 0, sb_b.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule